// File: doc/BRIEF.md
# Self-Test Command Handler with Lockout

This block sits on the device side of a serial sensor bus. It takes frames that have already been deframed and CRC-checked. Each frame carries a 4-bit command code, a 4-bit address and 8 data bits. The block acts on the disable-self-test, enable-self-test and clear commands. It keeps a self-test active flag and a sticky lockout. For every frame that is addressed to this device alone, it returns a short or a long status word, one cycle after the frame.

A small state machine counts consecutive disable commands:

- **IDLE**: no disable has been counted.
- **ONE_DIS**: one disable has been counted.
- **LOCKED**: self-test is locked out.

The transitions are:

- **IDLE → ONE_DIS** on an accepted disable.
- **ONE_DIS → LOCKED** on a second accepted disable.
- **ONE_DIS → IDLE** on any other accepted command.
- **LOCKED → IDLE** on an accepted clear command.
- **any → IDLE** while the supply-low input is high, or on a regulator reset or a frame-timeout reset.

A frame that goes to the global address is executed but gets no reply.

Top module: `selftest_cmd_handler`

## Requirements
- R1: An accepted frame with command code 4'b1100 (disable) clears `st_active` at the clock edge that samples it.
- R2: A frame is accepted only if `frm_addr` equals `dev_addr` or 4'b0000. Any other address leaves `st_active`, `lockout` and the disable count unchanged, and no response is produced.
- R3: A frame to address 4'b0000 is executed but produces no response.
- R4: The 8 data bits never change state or response.
- R5: Two consecutive accepted disables set `lockout`. While `lockout` is high, enable (command 4'b1010) is refused and `st_active` stays 0.
- R6: An accepted enable with no active lockout sets `st_active`. Any accepted command other than disable resets the consecutive-disable count.
- R7: A frame with `frm_crc_ok` low is dropped. It neither advances nor resets the disable count, and it gets no response.
- R8: An accepted clear command (4'b0110) clears `lockout`. `hcap_uv` high holds `lockout` and the count cleared, and frames are still executed in that cycle.
- R9: A `reg_uv_rst` or `frame_to_rst` pulse clears `lockout`, the count and `st_active`. A frame in that cycle is discarded.
- R10: The short response is `{8'b0, NV, U, ST, BS, AT[1], AT[0], S, 1'b0}`. NV is `otp_en`, U is `hcap_uv`, ST is `st_active` after the command, BS is `bus_sw`, AT is `cfg_attr` and S is `int_err`.
- R11: The long response is `{dev_addr, 4'b0000, low byte as in R10}`. `long_fmt` is sampled with the frame.
- R12: `rsp_valid` is high for exactly one cycle after each accepted, non-global frame, and at no other time. It is 0 after reset, as are `st_active` and `lockout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | A frame is present this cycle |
| frm_crc_ok | input | 1 | CRC check of the frame passed |
| frm_cmd | input | 4 | Command code |
| frm_addr | input | 4 | Frame address |
| frm_data | input | 8 | Data bits (CRC only) |
| dev_addr | input | 4 | Programmed device address |
| long_fmt | input | 1 | 1 selects the long response layout |
| hcap_uv | input | 1 | Reserve-capacitor supply below threshold |
| reg_uv_rst | input | 1 | Regulator under-voltage reset event |
| frame_to_rst | input | 1 | Frame timeout reset event |
| int_err | input | 1 | Internal error flag |
| bus_sw | input | 1 | Bus switch state |
| otp_en | input | 1 | One-time-programmable write enable |
| cfg_attr | input | 2 | Attribute bits from configuration |
| rsp_valid | output | 1 | Response strobe |
| rsp_word | output | 16 | Response word |
| st_active | output | 1 | Self-test active flag |
| lockout | output | 1 | Self-test lockout latch |

## Verification
The hardest state to reach is a count of one disable that must survive a dropped CRC frame without being reset. No port shows the count. The stimulus therefore sends a disable, then a corrupted disable, then a valid disable, and checks that lockout rises only after the third frame. A second sequence does the same with an enable placed between the two disables, and checks that lockout stays low. A further run sends the enable while the supply-low input is high and checks that the lockout is lifted in the same cycle, so the enable is honoured.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int RSP_W  = 16;

    localparam logic [CMD_W-1:0]  CMD_DISABLE = 4'b1100;
    localparam logic [CMD_W-1:0]  CMD_ENABLE  = 4'b1010;
    localparam logic [CMD_W-1:0]  CMD_CLEAR   = 4'b0110;
    localparam logic [ADDR_W-1:0] ADDR_GLOBAL = '0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ONE_DIS = 2'd1,
        ST_LOCKED  = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic       nv;
        logic       u;
        logic       bs;
        logic [1:0] at;
        logic       s;
    } status_t;
endpackage

// File: rtl/stc_decode.sv
module stc_decode
    import stc_pkg::*;
(
    input  logic              frm_valid,
    input  logic              frm_crc_ok,
    input  logic [CMD_W-1:0]  frm_cmd,
    input  logic [ADDR_W-1:0] frm_addr,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              sys_rst_evt,
    output logic              acc,
    output logic              is_bcast,
    output logic              is_dis,
    output logic              is_en,
    output logic              is_clr
);
    logic addr_hit;

    always_comb begin
        is_bcast = (frm_addr == ADDR_GLOBAL);
        addr_hit = is_bcast || (frm_addr == dev_addr);
        acc      = frm_valid && frm_crc_ok && addr_hit && !sys_rst_evt;
        is_dis   = (frm_cmd == CMD_DISABLE);
        is_en    = (frm_cmd == CMD_ENABLE);
        is_clr   = (frm_cmd == CMD_CLEAR);
    end
endmodule

// File: rtl/stc_lock_fsm.sv
module stc_lock_fsm
    import stc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic is_dis,
    input  logic is_en,
    input  logic is_clr,
    input  logic hcap_uv,
    input  logic sys_rst_evt,
    output logic st_active,
    output logic st_next,
    output logic lockout
);
    lock_state_e state_q, state_d;
    logic        st_q;
    logic        locked_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            st_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            st_q    <= st_next;
        end
    end

    always_comb begin
        state_d    = state_q;
        st_next    = st_q;
        locked_eff = (state_q == ST_LOCKED) && !hcap_uv;
        if (sys_rst_evt) begin
            state_d = ST_IDLE;
            st_next = 1'b0;
        end else begin
            if (acc) begin
                if (is_dis) begin
                    st_next = 1'b0;
                end else if (is_en && !locked_eff) begin
                    st_next = 1'b1;
                end
                unique case (state_q)
                    ST_IDLE:    state_d = is_dis ? ST_ONE_DIS : ST_IDLE;
                    ST_ONE_DIS: state_d = is_dis ? ST_LOCKED : ST_IDLE;
                    ST_LOCKED:  state_d = is_clr ? ST_IDLE : ST_LOCKED;
                    default:    state_d = ST_IDLE;
                endcase
            end
            if (hcap_uv) begin
                state_d = ST_IDLE;
            end
        end
    end

    assign st_active = st_q;
    assign lockout   = (state_q == ST_LOCKED);
endmodule

// File: rtl/stc_rsp_build.sv
module stc_rsp_build
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              long_fmt,
    input  logic [ADDR_W-1:0] dev_addr,
    input  status_t           sts,
    input  logic              st_next,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_word
);
    localparam int PAD_W = RSP_W - ADDR_W - 8;

    logic [7:0]       low_byte;
    logic [RSP_W-1:0] word_d;

    always_comb begin
        low_byte = {sts.nv, sts.u, st_next, sts.bs, sts.at, sts.s, 1'b0};
        if (long_fmt) begin
            word_d = {dev_addr, {PAD_W{1'b0}}, low_byte};
        end else begin
            word_d = {{(RSP_W-8){1'b0}}, low_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_word  <= '0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_word <= word_d;
            end
        end
    end
endmodule

// File: rtl/selftest_cmd_handler.sv
module selftest_cmd_handler
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_crc_ok,
    input  logic [CMD_W-1:0]  frm_cmd,
    input  logic [ADDR_W-1:0] frm_addr,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              long_fmt,
    input  logic              hcap_uv,
    input  logic              reg_uv_rst,
    input  logic              frame_to_rst,
    input  logic              int_err,
    input  logic              bus_sw,
    input  logic              otp_en,
    input  logic [1:0]        cfg_attr,
    output logic              rsp_valid,
    output logic [RSP_W-1:0]  rsp_word,
    output logic              st_active,
    output logic              lockout
);
    logic    sys_rst_evt;
    logic    acc, is_bcast, is_dis, is_en, is_clr;
    logic    st_next;
    logic    unused_data;
    status_t sts;

    // Data bits take part only in the CRC, which is checked upstream.
    assign unused_data = ^frm_data;
    assign sys_rst_evt = reg_uv_rst || frame_to_rst;
    assign sts = '{nv: otp_en, u: hcap_uv, bs: bus_sw, at: cfg_attr, s: int_err};

    stc_decode u_dec (
        .frm_valid   (frm_valid),
        .frm_crc_ok  (frm_crc_ok),
        .frm_cmd     (frm_cmd),
        .frm_addr    (frm_addr),
        .dev_addr    (dev_addr),
        .sys_rst_evt (sys_rst_evt),
        .acc         (acc),
        .is_bcast    (is_bcast),
        .is_dis      (is_dis),
        .is_en       (is_en),
        .is_clr      (is_clr)
    );

    stc_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (acc),
        .is_dis      (is_dis),
        .is_en       (is_en),
        .is_clr      (is_clr),
        .hcap_uv     (hcap_uv),
        .sys_rst_evt (sys_rst_evt),
        .st_active   (st_active),
        .st_next     (st_next),
        .lockout     (lockout)
    );

    stc_rsp_build u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (acc && !is_bcast),
        .long_fmt  (long_fmt),
        .dev_addr  (dev_addr),
        .sts       (sts),
        .st_next   (st_next),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word)
    );
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_valid,
    input logic        frm_crc_ok,
    input logic [3:0]  frm_cmd,
    input logic [3:0]  frm_addr,
    input logic [3:0]  dev_addr,
    input logic        long_fmt,
    input logic        hcap_uv,
    input logic        reg_uv_rst,
    input logic        frame_to_rst,
    input logic        rsp_valid,
    input logic [15:0] rsp_word,
    input logic        st_active,
    input logic        lockout
);
    logic no_evt, addr_ok, hit;
    assign no_evt  = !reg_uv_rst && !frame_to_rst;
    assign addr_ok = (frm_addr == dev_addr) || (frm_addr == 4'b0000);
    assign hit     = frm_valid && frm_crc_ok && addr_ok && no_evt;

    assert_dis_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit && frm_cmd == 4'b1100 |=> !st_active);

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !addr_ok && no_evt && !hcap_uv
        |=> $stable(st_active) && $stable(lockout) && !rsp_valid);

    assert_bcast_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_addr == 4'b0000 |=> !rsp_valid);

    assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !st_active);

    assert_crc_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_crc_ok && no_evt && !hcap_uv
        |=> $stable(st_active) && $stable(lockout) && !rsp_valid);

    assert_hcap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hcap_uv |=> !lockout);

    assert_rst_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !no_evt |=> !lockout && !st_active && !rsp_valid);

    assert_short_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(long_fmt) |-> rsp_word[15:8] == 8'h00 && !rsp_word[0]);

    assert_long_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(long_fmt) |-> rsp_word[15:12] == $past(dev_addr) && rsp_word[11:8] == 4'h0);

    assert_rsp_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(frm_valid && frm_crc_ok && frm_addr == dev_addr
                            && frm_addr != 4'b0000 && !reg_uv_rst && !frame_to_rst));
endmodule

bind selftest_cmd_handler stc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .frm_crc_ok   (frm_crc_ok),
    .frm_cmd      (frm_cmd),
    .frm_addr     (frm_addr),
    .dev_addr     (dev_addr),
    .long_fmt     (long_fmt),
    .hcap_uv      (hcap_uv),
    .reg_uv_rst   (reg_uv_rst),
    .frame_to_rst (frame_to_rst),
    .rsp_valid    (rsp_valid),
    .rsp_word     (rsp_word),
    .st_active    (st_active),
    .lockout      (lockout)
);

// File: tb/selftest_cmd_handler_tb.sv
`timescale 1ns/1ps
module selftest_cmd_handler_tb;
    localparam logic [3:0] DIS = 4'b1100, EN = 4'b1010, CLR = 4'b0110, NOP = 4'b0011;
    localparam logic [3:0] DEV = 4'h5;

    logic clk = 0, rst_n = 0;
    logic frm_valid = 0, frm_crc_ok = 0;
    logic [3:0] frm_cmd = 0, frm_addr = 0;
    logic [7:0] frm_data = 0;
    logic [3:0] dev_addr = DEV;
    logic long_fmt = 0, hcap_uv = 0, reg_uv_rst = 0, frame_to_rst = 0;
    logic int_err = 0, bus_sw = 0, otp_en = 0;
    logic [1:0] cfg_attr = 0;
    logic rsp_valid, st_active, lockout;
    logic [15:0] rsp_word;

    int n_chk = 0, n_fail = 0;
    bit m_st = 0, m_lock = 0, m_cnt = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    selftest_cmd_handler u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit lng, input bit st);
        logic [7:0] lo;
        lo = {otp_en, hcap_uv, st, bus_sw, cfg_attr, int_err, 1'b0};
        return lng ? {DEV, 4'h0, lo} : {8'h00, lo};
    endfunction

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R12 unexpected rsp_valid", rsp_word, 16'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rsp_word === e, t, rsp_word, e);
            end
        end
    end

    task automatic send(input logic [3:0] cmd, input logic [3:0] addr, input logic [7:0] data,
                        input bit crc, input bit lng, input string req);
        bit acc;
        acc = crc && (addr == DEV || addr == 4'h0);
        if (acc) begin
            if (cmd == DIS) begin
                m_st = 0;
                if (!m_lock) begin
                    if (m_cnt) begin m_lock = 1; m_cnt = 0; end
                    else m_cnt = 1;
                end
            end else begin
                if (cmd == EN && !(m_lock && !hcap_uv)) m_st = 1;
                if (m_lock) begin
                    if (cmd == CLR) m_lock = 0;
                end else m_cnt = 0;
            end
        end
        if (hcap_uv) begin m_lock = 0; m_cnt = 0; end
        if (acc && addr != 4'h0) begin
            exp_q.push_back(exp_word(lng, m_st));
            tag_q.push_back(lng ? {req, " R11 long word"} : {req, " R10 short word"});
        end
        frm_valid = 1; frm_crc_ok = crc; frm_cmd = cmd; frm_addr = addr;
        frm_data = data; long_fmt = lng;
        @(negedge clk);
        frm_valid = 0; frm_crc_ok = 0; frm_data = 8'hFF;
        #1;
        chk(st_active === m_st, {req, " st_active"}, {15'h0, st_active}, {15'h0, m_st});
        chk(lockout === m_lock, {req, " lockout"}, {15'h0, lockout}, {15'h0, m_lock});
        chk(exp_q.size() == 0, {req, " R12 response count"}, exp_q.size(), 0);
    endtask

    task automatic pulse_evt(input bit to);
        if (to) frame_to_rst = 1; else reg_uv_rst = 1;
        frm_valid = 1; frm_crc_ok = 1; frm_cmd = EN; frm_addr = DEV;
        @(negedge clk);
        frame_to_rst = 0; reg_uv_rst = 0; frm_valid = 0;
        m_st = 0; m_lock = 0; m_cnt = 0;
        #1;
        chk(!st_active && !lockout, "R9 reset event", {14'h0, st_active, lockout}, 0);
        @(negedge clk);
        chk(!rsp_valid, "R9 frame in reset cycle silent", {15'h0, rsp_valid}, 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!st_active && !lockout && !rsp_valid, "R12 reset state",
            {13'h0, rsp_valid, st_active, lockout}, 0);
        send(EN,  DEV, 8'h00, 1, 0, "R6 enable");
        send(DIS, DEV, 8'hA5, 1, 1, "R1 disable long");
        send(EN,  DEV, 8'h00, 1, 0, "R6 enable after one disable");
        send(DIS, DEV, 8'h00, 1, 0, "R6 disable");
        send(EN,  DEV, 8'h00, 1, 0, "R6 enable between");
        send(DIS, DEV, 8'h00, 1, 0, "R6 disable no lock");
        send(NOP, DEV, 8'h00, 1, 1, "R6 other cmd resets count");
        send(DIS, DEV, 8'h00, 1, 0, "R7 first disable");
        send(DIS, DEV, 8'h00, 0, 0, "R7 crc bad dropped");
        send(DIS, DEV, 8'h00, 1, 0, "R5 second disable locks");
        send(EN,  DEV, 8'h00, 1, 1, "R5 enable refused");
        send(DIS, DEV, 8'h00, 1, 0, "R5 disable while locked");
        send(CLR, 4'h9, 8'h00, 1, 0, "R2 foreign clear ignored");
        send(EN,  4'h3, 8'h00, 1, 0, "R2 foreign enable ignored");
        send(CLR, DEV, 8'h00, 1, 0, "R8 clear");
        send(EN,  DEV, 8'h00, 1, 0, "R8 enable after clear");
        send(DIS, DEV, 8'h00, 1, 0, "R7 disable");
        send(DIS, DEV, 8'h00, 0, 0, "R7 bad crc no advance check");
        chk(!lockout, "R7 no lock from bad crc", {15'h0, lockout}, 0);
        send(NOP, DEV, 8'h00, 1, 0, "R7 reset count");
        send(DIS, 4'h0, 8'h00, 1, 0, "R3 global disable");
        send(DIS, 4'h0, 8'h00, 1, 1, "R3 global disable locks");
        hcap_uv = 1;
        send(EN, DEV, 8'h00, 1, 0, "R8 enable under hcap_uv");
        hcap_uv = 0;
        send(DIS, DEV, 8'h00, 1, 0, "R4 disable data 00");
        send(DIS, DEV, 8'hFF, 1, 1, "R4 disable data FF");
        pulse_evt(1);
        send(EN, DEV, 8'h3C, 1, 0, "R4 enable with data");
        pulse_evt(0);
        otp_en = 1; bus_sw = 1; cfg_attr = 2'b10; int_err = 1;
        send(EN, DEV, 8'h00, 1, 0, "R10 status fields");
        cfg_attr = 2'b01; int_err = 0;
        send(NOP, DEV, 8'h00, 1, 1, "R11 status fields");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all responses seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule